// File: doc/BRIEF.md
# Task-Aware Mesh Route Selector

This block is the route computation stage of one router in a 5x5 mesh. The mesh joins CPU cores, GPU cores, shared cache slices and memory controllers. For each packet header it returns the output port of this router and the virtual channel the packet may use on the next hop. The router's own coordinates and the packet's destination coordinates, task class, arrival channel and mode bit are its inputs.

The task class selects the dimension order. Core requests and cache-to-GPU replies go X-first. Cache-to-CPU replies and cache/memory-controller traffic go Y-first. The mode bit selects how the two virtual channels are used. In task mode, channel 0 carries task-ordered traffic and channel 1 is an escape channel that always routes X-first. In partitioned mode, each channel is dedicated to one dimension order.

The result is registered, so it is valid one clock after the header is presented. Buffering, arbitration, the crossbar and the policy that chooses the mode are outside the block.

Top module: `mesh_route_sel`

## Requirements
- R1: While `rst` is high at a clock edge, the following clock leaves `out_valid`, `out_port` and `out_vc` all zero.
- R2: A header presented with `in_valid` high produces its result on the outputs after the next rising edge, with `out_valid` high. After a cycle with `in_valid` low, `out_valid` is 0 and `out_port` is 0.
- R3: When the destination equals the router's own coordinates, `out_port` is the local code 5'b00001, whatever the class, mode or arrival channel.
- R4: Port bits are bit1 north (destination y greater than own y), bit2 south (destination y smaller), bit3 east (destination x greater) and bit4 west (destination x smaller). A move in a dimension is taken only when the coordinates differ in that dimension.
- R5: Task classes 2'b00 (core request) and 2'b10 (cache-to-GPU reply) use X-first order: x is corrected before y.
- R6: Task classes 2'b01 (cache-to-CPU reply) and 2'b11 (cache/memory-controller traffic) use Y-first order: y is corrected before x.
- R7: In task mode (`part_mode`=0) with `in_vc`=0, the class order of R5/R6 applies and `out_vc` is 0.
- R8: In task mode with `in_vc`=1 (escape channel), X-first order applies to every class and `out_vc` is 1.
- R9: In partitioned mode (`part_mode`=1), `out_vc` is 0 for X-first classes and 1 for Y-first classes. `in_vc` has no effect on the port or the channel.
- R10: Whenever `out_valid` is high, exactly one bit of `out_port` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header present this cycle |
| cur_x | input | 3 | Own column |
| cur_y | input | 3 | Own row |
| dst_x | input | 3 | Destination column |
| dst_y | input | 3 | Destination row |
| task_cls | input | 2 | Task class |
| part_mode | input | 1 | 0 task mode, 1 partitioned mode |
| in_vc | input | 1 | Channel the packet arrived on |
| out_valid | output | 1 | Result valid |
| out_port | output | 5 | One-hot output port |
| out_vc | output | 1 | Permitted next-hop channel |

## Verification
Two decisions can land on the same header: the escape-channel override of the dimension order, and the class order combined with the mode's channel mapping. Local delivery can also coincide with either one. The bench provokes every such overlap by sweeping all own positions, destinations, classes, modes and arrival channels, one header per clock. Each registered result is compared one cycle later against a behavioural model that resolves the overrides in the order the requirements state. Headers with `in_vc`=1 in partitioned mode show that the arrival channel is ignored there.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;
  typedef enum logic [1:0] {
    CLS_CORE_REQ  = 2'b00,
    CLS_CPU_REPLY = 2'b01,
    CLS_GPU_REPLY = 2'b10,
    CLS_HOT_MC    = 2'b11
  } task_cls_e;

  localparam int PORTS   = 5;
  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_SOUTH = 2;
  localparam int P_EAST  = 3;
  localparam int P_WEST  = 4;
endpackage

// File: rtl/mesh_route_order.sv
module mesh_route_order
  import mesh_route_pkg::*;
(
  input  logic [1:0] task_cls,
  input  logic       part_mode,
  input  logic       in_vc,
  output logic       y_first,
  output logic       vc_sel
);
  logic cls_y_first;

  always_comb begin
    unique case (task_cls_e'(task_cls))
      CLS_CPU_REPLY, CLS_HOT_MC: cls_y_first = 1'b1;
      default:                   cls_y_first = 1'b0;
    endcase
  end

  always_comb begin
    if (part_mode) begin
      y_first = cls_y_first;
      vc_sel  = cls_y_first;
    end else if (in_vc) begin
      y_first = 1'b0;
      vc_sel  = 1'b1;
    end else begin
      y_first = cls_y_first;
      vc_sel  = 1'b0;
    end
  end
endmodule

// File: rtl/mesh_route_dir.sv
module mesh_route_dir
  import mesh_route_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input  logic [XW-1:0]    cur_x,
  input  logic [YW-1:0]    cur_y,
  input  logic [XW-1:0]    dst_x,
  input  logic [YW-1:0]    dst_y,
  input  logic             y_first,
  output logic [PORTS-1:0] port
);
  logic x_diff, y_diff;
  logic [PORTS-1:0] x_step, y_step;

  assign x_diff = (dst_x != cur_x);
  assign y_diff = (dst_y != cur_y);

  always_comb begin
    x_step = '0;
    y_step = '0;
    if (dst_x > cur_x) x_step[P_EAST]  = 1'b1;
    else               x_step[P_WEST]  = 1'b1;
    if (dst_y > cur_y) y_step[P_NORTH] = 1'b1;
    else               y_step[P_SOUTH] = 1'b1;
  end

  always_comb begin
    port = '0;
    if (!x_diff && !y_diff)   port[P_LOCAL] = 1'b1;
    else if (y_first) port = y_diff ? y_step : x_step;
    else              port = x_diff ? x_step : y_step;
  end
endmodule

// File: rtl/mesh_route_sel.sv
module mesh_route_sel
  import mesh_route_pkg::*;
#(
  parameter int MESH_W = 5,
  parameter int MESH_H = 5,
  localparam int XW = (MESH_W > 1) ? $clog2(MESH_W) : 1,
  localparam int YW = (MESH_H > 1) ? $clog2(MESH_H) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  input  logic [1:0]    task_cls,
  input  logic          part_mode,
  input  logic          in_vc,
  output logic          out_valid,
  output logic [4:0]    out_port,
  output logic          out_vc
);
  logic             y_first;
  logic             vc_next;
  logic [PORTS-1:0] port_next;

  mesh_route_order u_order (
    .task_cls  (task_cls),
    .part_mode (part_mode),
    .in_vc     (in_vc),
    .y_first   (y_first),
    .vc_sel    (vc_next)
  );

  mesh_route_dir #(.XW(XW), .YW(YW)) u_dir (
    .cur_x   (cur_x),
    .cur_y   (cur_y),
    .dst_x   (dst_x),
    .dst_y   (dst_y),
    .y_first (y_first),
    .port    (port_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_vc    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_port  <= in_valid ? port_next : '0;
      out_vc    <= in_valid ? vc_next : 1'b0;
    end
  end
endmodule

// File: rtl/mesh_route_sel_chk.sv
module mesh_route_sel_chk #(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [XW-1:0] cur_x,
  input logic [YW-1:0] cur_y,
  input logic [XW-1:0] dst_x,
  input logic [YW-1:0] dst_y,
  input logic [1:0]    task_cls,
  input logic          part_mode,
  input logic          in_vc,
  input logic          out_valid,
  input logic [4:0]    out_port,
  input logic          out_vc
);
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && out_port == 5'b0)); // R2

  AST_LOCAL_DELIVERY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_x == cur_x && dst_y == cur_y) |=> out_port == 5'b00001); // R3

  AST_ESCAPE_X_FIRST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !part_mode && in_vc && dst_x != cur_x)
      |=> (out_vc && (out_port == 5'b01000 || out_port == 5'b10000))); // R8

  AST_CPU_REPLY_Y_FIRST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && task_cls == 2'b01 && !(!part_mode && in_vc) && dst_y != cur_y)
      |=> (out_port == 5'b00010 || out_port == 5'b00100)); // R6

  AST_PART_VC_MAP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && part_mode) |=> out_vc == $past(task_cls[0])); // R9

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(out_port) == 1); // R10
endmodule

bind mesh_route_sel mesh_route_sel_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cur_x     (cur_x),
  .cur_y     (cur_y),
  .dst_x     (dst_x),
  .dst_y     (dst_y),
  .task_cls  (task_cls),
  .part_mode (part_mode),
  .in_vc     (in_vc),
  .out_valid (out_valid),
  .out_port  (out_port),
  .out_vc    (out_vc)
);

// File: tb/mesh_route_sel_bench.sv
`timescale 1ns/1ps
module mesh_route_sel_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
  logic [1:0] task_cls = '0;
  logic       part_mode = 1'b0, in_vc = 1'b0;
  logic       out_valid;
  logic [4:0] out_port;
  logic       out_vc;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mesh_route_sel u_mesh_route_sel (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .task_cls(task_cls), .part_mode(part_mode), .in_vc(in_vc),
    .out_valid(out_valid), .out_port(out_port), .out_vc(out_vc)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model: returns {vc, port}
  function automatic int model(int cx, int cy, int dx, int dy, int cls, int pm, int iv);
    bit yfirst;
    int vc;
    int port;
    yfirst = (cls == 1 || cls == 3);
    if (pm == 0 && iv == 1) begin
      yfirst = 0;   // R8 escape
      vc = 1;
    end else if (pm == 1) vc = yfirst ? 1 : 0;  // R9
    else vc = 0;                                 // R7
    if (cx == dx && cy == dy) port = 1;          // R3
    else if (yfirst && cy != dy) port = (dy > cy) ? 2 : 4;
    else if (!yfirst && cx != dx) port = (dx > cx) ? 8 : 16;
    else if (cx != dx) port = (dx > cx) ? 8 : 16;
    else port = (dy > cy) ? 2 : 4;
    return vc * 32 + port;
  endfunction

  task automatic send(int cx, int cy, int dx, int dy, int cls, int pm, int iv);
    int exp;
    @(negedge clk);
    in_valid = 1'b1;
    cur_x = 3'(cx); cur_y = 3'(cy); dst_x = 3'(dx); dst_y = 3'(dy);
    task_cls = 2'(cls); part_mode = pm[0]; in_vc = iv[0];
    exp = model(cx, cy, dx, dy, cls, pm, iv);
    @(posedge clk); #1;
    check("R2 valid", int'(out_valid), 1);
    if (cx == dx && cy == dy)  check("R3 local", int'(out_port), exp % 32);
    else if (pm == 0 && iv == 1) check("R8 escape", int'(out_port), exp % 32);
    else if (cls == 1 || cls == 3) check("R6 y-first", int'(out_port), exp % 32);
    else check("R5 x-first R4", int'(out_port), exp % 32);
    if (pm == 1) check("R9 part vc", int'(out_vc), exp / 32);
    else check("R7 R8 task vc", int'(out_vc), exp / 32);
    check("R10 one-hot", $countones(out_port), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset port", int'(out_port), 0);
    check("R1 reset vc", int'(out_vc), 0);
    @(negedge clk); rst = 1'b0;
    for (int pm = 0; pm < 2; pm++)
      for (int iv = 0; iv < 2; iv++)
        for (int cls = 0; cls < 4; cls++)
          for (int cx = 0; cx < 5; cx++)
            for (int cy = 0; cy < 5; cy++)
              for (int dx = 0; dx < 5; dx++)
                for (int dy = 0; dy < 5; dy++)
                  send(cx, cy, dx, dy, cls, pm, iv);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    check("R2 idle valid", int'(out_valid), 0);
    check("R2 idle port", int'(out_port), 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule